// File: doc/BRIEF.md
# One-to-N Request Steering Socket

This block sits between one host port and `NumDev` device ports of a valid/ready split-transaction bus (request channel "A", response channel "D"). An address decoder outside the block turns each request's address into a device-select index that arrives with the request. The socket steers the request to the selected device, merges the devices' responses back onto the host port, and answers requests whose index is not a real device through an internal error responder.

Responses must come back in request order, so the socket counts outstanding transactions and records the port that was last targeted. A request to another port waits until that count falls to zero. Requests to the same port can be pipelined up to `MaxOut` deep. Request payload fields are broadcast to every device port. Only the `a_valid` of the selected port is raised. Devices must answer no earlier than the cycle after they accept a request.

Top module: `bus_fanout_socket`

## Requirements
- R1: With a select value below `NumDev` and the request allowed to issue, only that port's `dev_a_valid_o` bit is high. Opcode, size, source, address, mask, data and user reach the device ports unchanged.
- R2: `host_a_ready_o` equals the selected port's `dev_a_ready_i` whenever the request is allowed to issue.
- R3: While at least one transaction is outstanding to one target, a request for a different target raises no `dev_a_valid_o` bit and sees `host_a_ready_o` low.
- R4: Requests to the target already outstanding may issue back to back until `MaxOut` transactions are outstanding. At that count no further request issues until a response completes.
- R5: While transactions are outstanding to device port k, that port's response valid, opcode, error, size, source, user and data appear unchanged on the host response port, and `dev_d_ready_o` is high only on port k and only while `host_d_ready_i` is high.
- R6: A select value of `NumDev` or above is taken by the internal responder. In the cycle after acceptance it raises `host_d_valid_o` with error set, data zero, and the request's source, size and user echoed. The response is held until the host accepts it.
- R7: The error response code is 1 (data acknowledge) for a read request (opcode 4). For a full write (opcode 0), a partial write (opcode 1) or any other opcode the code is 0 (plain acknowledge).
- R8: The error responder holds at most one request. While its response is pending, a further out-of-range request sees `host_a_ready_o` low.
- R9: With no transaction outstanding, device response valids are ignored: `host_d_valid_o` stays low and every `dev_d_ready_o` bit stays low.
- R10: During and right after reset nothing is outstanding. The response path is closed and the first request may go to any target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_a_valid_i | input | 1 | Host request valid |
| host_a_opcode_i | input | 3 | Request opcode (0 full write, 1 partial write, 4 read) |
| host_a_size_i | input | SizeW | Request size, log2 of bytes |
| host_a_source_i | input | SrcW | Request identifier |
| host_a_address_i | input | AddrW | Request address |
| host_a_mask_i | input | ByteW | Byte-lane enables |
| host_a_data_i | input | DataW | Write data |
| host_a_user_i | input | UserW | Request sideband bits |
| host_sel_i | input | SelW | Target index, valid whenever host_a_valid_i is high |
| host_a_ready_o | output | 1 | Request accepted |
| host_d_valid_o | output | 1 | Response valid |
| host_d_opcode_o | output | 3 | Response code (0 ack, 1 ack with data) |
| host_d_size_o | output | SizeW | Response size |
| host_d_source_o | output | SrcW | Returned request identifier |
| host_d_data_o | output | DataW | Read data |
| host_d_user_o | output | UserW | Response sideband bits |
| host_d_error_o | output | 1 | Response error flag |
| host_d_ready_i | input | 1 | Host accepts response |
| dev_a_valid_o | output | NumDev | Per-port request valid |
| dev_a_opcode_o | output | 3 | Broadcast request opcode |
| dev_a_size_o | output | SizeW | Broadcast request size |
| dev_a_source_o | output | SrcW | Broadcast request identifier |
| dev_a_address_o | output | AddrW | Broadcast request address |
| dev_a_mask_o | output | ByteW | Broadcast byte enables |
| dev_a_data_o | output | DataW | Broadcast write data |
| dev_a_user_o | output | UserW | Broadcast request sideband |
| dev_a_ready_i | input | NumDev | Per-port request ready |
| dev_d_valid_i | input | NumDev | Per-port response valid |
| dev_d_opcode_i | input | NumDev*3 | Per-port response code, port k in bits [3k+2:3k] |
| dev_d_size_i | input | NumDev*SizeW | Per-port response size |
| dev_d_source_i | input | NumDev*SrcW | Per-port response identifier |
| dev_d_data_i | input | NumDev*DataW | Per-port response data |
| dev_d_user_i | input | NumDev*UserW | Per-port response sideband |
| dev_d_error_i | input | NumDev | Per-port response error |
| dev_d_ready_o | output | NumDev | Per-port response ready |

## Verification
Several properties are checked on every cycle. At most one port sees a request valid. A request for a different target is stalled while others are outstanding. The outstanding count never passes `MaxOut` and never underflows. An error response appears one cycle after acceptance and stays stable until the host takes it. The response path stays closed when nothing is outstanding. Only the bench's scenarios show the rest: field-exact pass-through of payloads, the opcode-dependent error code, saturation followed by release, and recovery after a blocked switch between targets. A behavioural model predicts every output on every cycle, and its directed and random traffic exercise these scenarios.

// File: rtl/fanout_pkg.sv
package fanout_pkg;

   typedef enum logic [2:0] {
      OP_PUT_FULL = 3'd0,
      OP_PUT_PART = 3'd1,
      OP_GET      = 3'd4
   } req_op_e;

   typedef enum logic [2:0] {
      RSP_ACK      = 3'd0,
      RSP_ACK_DATA = 3'd1
   } rsp_op_e;

   // Response code that matches a request opcode
   function automatic logic [2:0] ack_code(input logic [2:0] op);
      return (op == OP_GET) ? RSP_ACK_DATA : RSP_ACK;
   endfunction

endpackage

// File: rtl/fanout_order_guard.sv
module fanout_order_guard #(
   parameter int unsigned NumDev = 4,
   parameter int unsigned MaxOut = 4,
   parameter int unsigned SelW   = 3,
   localparam int unsigned CntW  = $clog2(MaxOut + 1)
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [SelW-1:0] tgt_i,
   input  logic            req_accept_i,
   input  logic            rsp_done_i,
   output logic            issue_ok_o,
   output logic            busy_o,
   output logic [SelW-1:0] last_tgt_o
);

   logic [CntW-1:0] cnt_q;
   logic [SelW-1:0] last_q;

   assign busy_o     = (cnt_q != '0);
   assign last_tgt_o = last_q;
   assign issue_ok_o = (!busy_o || (tgt_i == last_q)) && (cnt_q != CntW'(MaxOut));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         last_q <= '0;
      end else begin
         case ({req_accept_i, rsp_done_i})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
         if (req_accept_i) last_q <= tgt_i;
      end
   end

   // R4: no acceptance once the window is full
   p_sat_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == CntW'(MaxOut)) |-> !req_accept_i);

   // R9: a completion only ever retires something outstanding
   p_no_underflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_done_i |-> (cnt_q != '0));

endmodule

// File: rtl/fanout_err_responder.sv
module fanout_err_responder
   import fanout_pkg::*;
#(
   parameter int unsigned SrcW  = 8,
   parameter int unsigned SizeW = 2,
   parameter int unsigned UserW = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             req_i,
   input  logic [2:0]       opcode_i,
   input  logic [SizeW-1:0] size_i,
   input  logic [SrcW-1:0]  source_i,
   input  logic [UserW-1:0] user_i,
   output logic             ready_o,
   output logic             rsp_valid_o,
   output logic [2:0]       rsp_opcode_o,
   output logic [SizeW-1:0] rsp_size_o,
   output logic [SrcW-1:0]  rsp_source_o,
   output logic [UserW-1:0] rsp_user_o,
   input  logic             rsp_ready_i
);

   logic             pend_q;
   logic [2:0]       code_q;
   logic [SizeW-1:0] size_q;
   logic [SrcW-1:0]  src_q;
   logic [UserW-1:0] user_q;

   assign ready_o      = !pend_q;
   assign rsp_valid_o  = pend_q;
   assign rsp_opcode_o = code_q;
   assign rsp_size_o   = size_q;
   assign rsp_source_o = src_q;
   assign rsp_user_o   = user_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q <= 1'b0;
         code_q <= '0;
         size_q <= '0;
         src_q  <= '0;
         user_q <= '0;
      end else if (req_i && !pend_q) begin
         pend_q <= 1'b1;
         code_q <= ack_code(opcode_i);
         size_q <= size_i;
         src_q  <= source_i;
         user_q <= user_i;
      end else if (pend_q && rsp_ready_i) begin
         pend_q <= 1'b0;
      end
   end

   // R6: response follows acceptance by one cycle and echoes the request
   p_err_echo_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && ready_o) |=> (rsp_valid_o && rsp_source_o == $past(source_i)
                              && rsp_size_o == $past(size_i)));

   // R6: a pending response is held until taken
   p_err_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_source_o)
                                         && $stable(rsp_opcode_o)));

endmodule

// File: rtl/bus_fanout_socket.sv
module bus_fanout_socket
   import fanout_pkg::*;
#(
   parameter int unsigned NumDev = 4,
   parameter int unsigned AddrW  = 16,
   parameter int unsigned DataW  = 32,
   parameter int unsigned SrcW   = 8,
   parameter int unsigned UserW  = 4,
   parameter int unsigned MaxOut = 4,
   localparam int unsigned ByteW = DataW / 8,
   localparam int unsigned SizeW = $clog2($clog2(ByteW) + 1),
   localparam int unsigned SelW  = $clog2(NumDev + 1)
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    host_a_valid_i,
   input  logic [2:0]              host_a_opcode_i,
   input  logic [SizeW-1:0]        host_a_size_i,
   input  logic [SrcW-1:0]         host_a_source_i,
   input  logic [AddrW-1:0]        host_a_address_i,
   input  logic [ByteW-1:0]        host_a_mask_i,
   input  logic [DataW-1:0]        host_a_data_i,
   input  logic [UserW-1:0]        host_a_user_i,
   input  logic [SelW-1:0]         host_sel_i,
   output logic                    host_a_ready_o,
   output logic                    host_d_valid_o,
   output logic [2:0]              host_d_opcode_o,
   output logic [SizeW-1:0]        host_d_size_o,
   output logic [SrcW-1:0]         host_d_source_o,
   output logic [DataW-1:0]        host_d_data_o,
   output logic [UserW-1:0]        host_d_user_o,
   output logic                    host_d_error_o,
   input  logic                    host_d_ready_i,
   output logic [NumDev-1:0]       dev_a_valid_o,
   output logic [2:0]              dev_a_opcode_o,
   output logic [SizeW-1:0]        dev_a_size_o,
   output logic [SrcW-1:0]         dev_a_source_o,
   output logic [AddrW-1:0]        dev_a_address_o,
   output logic [ByteW-1:0]        dev_a_mask_o,
   output logic [DataW-1:0]        dev_a_data_o,
   output logic [UserW-1:0]        dev_a_user_o,
   input  logic [NumDev-1:0]       dev_a_ready_i,
   input  logic [NumDev-1:0]       dev_d_valid_i,
   input  logic [NumDev*3-1:0]     dev_d_opcode_i,
   input  logic [NumDev*SizeW-1:0] dev_d_size_i,
   input  logic [NumDev*SrcW-1:0]  dev_d_source_i,
   input  logic [NumDev*DataW-1:0] dev_d_data_i,
   input  logic [NumDev*UserW-1:0] dev_d_user_i,
   input  logic [NumDev-1:0]       dev_d_error_i,
   output logic [NumDev-1:0]       dev_d_ready_o
);

   localparam logic [SelW-1:0] ErrTgt = SelW'(NumDev);

   if (NumDev < 2 || NumDev > 15) begin : g_bad_numdev
      $error("NumDev must lie in 2..15");
   end
   if (MaxOut < 1) begin : g_bad_maxout
      $error("MaxOut must be at least 1");
   end
   if (DataW % 8 != 0 || DataW < 16) begin : g_bad_dataw
      $error("DataW must be a multiple of 8 and at least 16");
   end

   logic [SelW-1:0]  tgt;
   logic             to_err;
   logic             issue_ok;
   logic             busy;
   logic [SelW-1:0]  last_tgt;
   logic             sel_ready;
   logic             req_accept;
   logic             rsp_done;
   logic             err_ready;
   logic             err_rsp_valid;
   logic             err_rsp_ready;
   logic [2:0]       err_rsp_opcode;
   logic [SizeW-1:0] err_rsp_size;
   logic [SrcW-1:0]  err_rsp_source;
   logic [UserW-1:0] err_rsp_user;

   // Out-of-range selects collapse onto one internal target
   assign tgt    = (host_sel_i >= ErrTgt) ? ErrTgt : host_sel_i;
   assign to_err = (tgt == ErrTgt);

   fanout_order_guard #(
      .NumDev (NumDev),
      .MaxOut (MaxOut),
      .SelW   (SelW)
   ) i_guard (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .tgt_i        (tgt),
      .req_accept_i (req_accept),
      .rsp_done_i   (rsp_done),
      .issue_ok_o   (issue_ok),
      .busy_o       (busy),
      .last_tgt_o   (last_tgt)
   );

   fanout_err_responder #(
      .SrcW  (SrcW),
      .SizeW (SizeW),
      .UserW (UserW)
   ) i_err (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .req_i        (host_a_valid_i && issue_ok && to_err),
      .opcode_i     (host_a_opcode_i),
      .size_i       (host_a_size_i),
      .source_i     (host_a_source_i),
      .user_i       (host_a_user_i),
      .ready_o      (err_ready),
      .rsp_valid_o  (err_rsp_valid),
      .rsp_opcode_o (err_rsp_opcode),
      .rsp_size_o   (err_rsp_size),
      .rsp_source_o (err_rsp_source),
      .rsp_user_o   (err_rsp_user),
      .rsp_ready_i  (err_rsp_ready)
   );

   // Request path
   always_comb begin
      sel_ready = to_err ? err_ready : 1'b0;
      for (int i = 0; i < int'(NumDev); i++) begin
         if (tgt == SelW'(i)) sel_ready = dev_a_ready_i[i];
      end
   end

   assign host_a_ready_o  = issue_ok && sel_ready;
   assign req_accept      = host_a_valid_i && host_a_ready_o;
   assign dev_a_opcode_o  = host_a_opcode_i;
   assign dev_a_size_o    = host_a_size_i;
   assign dev_a_source_o  = host_a_source_i;
   assign dev_a_address_o = host_a_address_i;
   assign dev_a_mask_o    = host_a_mask_i;
   assign dev_a_data_o    = host_a_data_i;
   assign dev_a_user_o    = host_a_user_i;

   for (genvar g = 0; g < int'(NumDev); g++) begin : g_port
      assign dev_a_valid_o[g] = host_a_valid_i && issue_ok && (tgt == SelW'(g));
      assign dev_d_ready_o[g] = host_d_ready_i && busy && (last_tgt == SelW'(g));
   end

   // Response path: only the target of the outstanding run may answer
   assign err_rsp_ready = host_d_ready_i && busy && (last_tgt == ErrTgt);

   always_comb begin
      host_d_valid_o  = 1'b0;
      host_d_opcode_o = '0;
      host_d_size_o   = '0;
      host_d_source_o = '0;
      host_d_data_o   = '0;
      host_d_user_o   = '0;
      host_d_error_o  = 1'b0;
      if (busy) begin
         if (last_tgt == ErrTgt) begin
            host_d_valid_o  = err_rsp_valid;
            host_d_opcode_o = err_rsp_opcode;
            host_d_size_o   = err_rsp_size;
            host_d_source_o = err_rsp_source;
            host_d_user_o   = err_rsp_user;
            host_d_error_o  = 1'b1;
         end
         for (int i = 0; i < int'(NumDev); i++) begin
            if (last_tgt == SelW'(i)) begin
               host_d_valid_o  = dev_d_valid_i[i];
               host_d_opcode_o = dev_d_opcode_i[i*3 +: 3];
               host_d_size_o   = dev_d_size_i[i*SizeW +: SizeW];
               host_d_source_o = dev_d_source_i[i*SrcW +: SrcW];
               host_d_data_o   = dev_d_data_i[i*DataW +: DataW];
               host_d_user_o   = dev_d_user_i[i*UserW +: UserW];
               host_d_error_o  = dev_d_error_i[i];
            end
         end
      end
   end

   assign rsp_done = host_d_valid_o && host_d_ready_i;

   // R1: at most one device port sees a request
   p_one_port_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(dev_a_valid_o));

   // R3: a switch of target waits for the outstanding run to drain
   p_hold_switch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy && host_a_valid_i && tgt != last_tgt) |-> (!host_a_ready_o && dev_a_valid_o == '0));

   // R9: nothing outstanding means the response path is closed
   p_idle_closed_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy |-> (!host_d_valid_o && dev_d_ready_o == '0));

   // R8: a second out-of-range request waits for the pending error response
   p_err_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_rsp_valid && host_a_valid_i && to_err) |-> !host_a_ready_o);

endmodule

// File: tb/test_bus_fanout_socket.sv
module test_bus_fanout_socket;

   localparam int N  = 4;
   localparam int AW = 16;
   localparam int DW = 32;
   localparam int IW = 8;
   localparam int UW = 4;
   localparam int MO = 4;
   localparam int BW = DW / 8;
   localparam int SZ = 2;
   localparam int SW = 3;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n;
   logic          a_valid;
   logic [2:0]    a_op;
   logic [SZ-1:0] a_size;
   logic [IW-1:0] a_src;
   logic [AW-1:0] a_addr;
   logic [BW-1:0] a_mask;
   logic [DW-1:0] a_data;
   logic [UW-1:0] a_user;
   logic [SW-1:0] sel;
   logic          h_dready;

   logic          a_ready;
   logic          d_valid;
   logic [2:0]    d_op;
   logic [SZ-1:0] d_size;
   logic [IW-1:0] d_src;
   logic [DW-1:0] d_data;
   logic [UW-1:0] d_user;
   logic          d_err;

   logic [N-1:0]  dv_aval;
   logic [2:0]    dv_op;
   logic [SZ-1:0] dv_size;
   logic [IW-1:0] dv_src;
   logic [AW-1:0] dv_addr;
   logic [BW-1:0] dv_mask;
   logic [DW-1:0] dv_data;
   logic [UW-1:0] dv_user;
   logic [N-1:0]  dv_ardy;
   logic [N-1:0]  dv_dval;
   logic [N-1:0]  dv_derr;
   logic [N-1:0]  dv_dready;

   logic [2:0]    r_op   [N];
   logic [SZ-1:0] r_size [N];
   logic [IW-1:0] r_src  [N];
   logic [DW-1:0] r_data [N];
   logic [UW-1:0] r_user [N];

   logic [N*3-1:0]  p_op;
   logic [N*SZ-1:0] p_size;
   logic [N*IW-1:0] p_src;
   logic [N*DW-1:0] p_data;
   logic [N*UW-1:0] p_user;

   always_comb begin
      for (int i = 0; i < N; i++) begin
         p_op[i*3 +: 3]     = r_op[i];
         p_size[i*SZ +: SZ] = r_size[i];
         p_src[i*IW +: IW]  = r_src[i];
         p_data[i*DW +: DW] = r_data[i];
         p_user[i*UW +: UW] = r_user[i];
      end
   end

   bus_fanout_socket #(
      .NumDev (N), .AddrW (AW), .DataW (DW), .SrcW (IW), .UserW (UW), .MaxOut (MO)
   ) i_bus_fanout_socket (
      .clk_i (clk), .rst_ni (rst_n),
      .host_a_valid_i (a_valid), .host_a_opcode_i (a_op), .host_a_size_i (a_size),
      .host_a_source_i (a_src), .host_a_address_i (a_addr), .host_a_mask_i (a_mask),
      .host_a_data_i (a_data), .host_a_user_i (a_user), .host_sel_i (sel),
      .host_a_ready_o (a_ready),
      .host_d_valid_o (d_valid), .host_d_opcode_o (d_op), .host_d_size_o (d_size),
      .host_d_source_o (d_src), .host_d_data_o (d_data), .host_d_user_o (d_user),
      .host_d_error_o (d_err), .host_d_ready_i (h_dready),
      .dev_a_valid_o (dv_aval), .dev_a_opcode_o (dv_op), .dev_a_size_o (dv_size),
      .dev_a_source_o (dv_src), .dev_a_address_o (dv_addr), .dev_a_mask_o (dv_mask),
      .dev_a_data_o (dv_data), .dev_a_user_o (dv_user), .dev_a_ready_i (dv_ardy),
      .dev_d_valid_i (dv_dval), .dev_d_opcode_i (p_op), .dev_d_size_i (p_size),
      .dev_d_source_i (p_src), .dev_d_data_i (p_data), .dev_d_user_i (p_user),
      .dev_d_error_i (dv_derr), .dev_d_ready_o (dv_dready)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // Reference model state
   int            m_cnt = 0;
   int            m_last = 0;
   bit            m_eb = 0;
   logic [2:0]    m_eop = '0;
   logic [SZ-1:0] m_esize = '0;
   logic [IW-1:0] m_esrc = '0;
   logic [UW-1:0] m_euser = '0;

   task automatic chk(input string tag, input string what, input logic [127:0] act,
                      input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
      end
   endtask

   // One clock: compare every output against the model, then advance the model
   task automatic cycle();
      int tgt;
      bit blocked, sat, allowed, rdy, acc, done, e_dv;
      string tq, tr;
      logic [2:0] e_op;
      logic [SZ-1:0] e_size;
      logic [IW-1:0] e_src;
      logic [DW-1:0] e_data;
      logic [UW-1:0] e_user;
      bit e_err;
      #1;
      tgt     = (int'(sel) >= N) ? N : int'(sel);
      blocked = (m_cnt != 0) && (tgt != m_last);
      sat     = (m_cnt >= MO);
      allowed = !blocked && !sat;
      tq      = blocked ? "R3" : sat ? "R4" : (tgt == N) ? "R6" : "R1";
      for (int i = 0; i < N; i++)
         chk(tq, $sformatf("dev_a_valid[%0d]", i), 128'(dv_aval[i]),
             128'(a_valid && allowed && tgt == i));
      if (a_valid && allowed && tgt < N)
         chk("R1", "payload", {dv_op, dv_size, dv_src, dv_addr, dv_mask, dv_data, dv_user},
             {a_op, a_size, a_src, a_addr, a_mask, a_data, a_user});
      rdy = allowed && ((tgt == N) ? !m_eb : dv_ardy[tgt]);
      chk((tgt == N && allowed) ? "R8" : blocked ? "R3" : sat ? "R4" : "R2",
          "host_a_ready", 128'(a_ready), 128'(rdy));
      acc = a_valid && rdy;

      e_dv = 0; e_op = '0; e_size = '0; e_src = '0; e_data = '0; e_user = '0; e_err = 0;
      if (m_cnt != 0) begin
         if (m_last == N) begin
            e_dv = m_eb; e_op = m_eop; e_size = m_esize; e_src = m_esrc;
            e_user = m_euser; e_err = 1;
         end else begin
            e_dv = dv_dval[m_last]; e_op = r_op[m_last]; e_size = r_size[m_last];
            e_src = r_src[m_last]; e_data = r_data[m_last]; e_user = r_user[m_last];
            e_err = dv_derr[m_last];
         end
      end
      tr = (m_cnt == 0) ? "R9" : (m_last == N) ? "R6" : "R5";
      chk(tr, "host_d_valid", 128'(d_valid), 128'(e_dv));
      if (e_dv) begin
         chk(tr, "rsp fields", {d_size, d_src, d_data, d_user, d_err},
             {e_size, e_src, e_data, e_user, e_err});
         chk((m_last == N) ? "R7" : "R5", "rsp opcode", 128'(d_op), 128'(e_op));
      end
      for (int i = 0; i < N; i++)
         chk(tr, $sformatf("dev_d_ready[%0d]", i), 128'(dv_dready[i]),
             128'(h_dready && m_cnt != 0 && m_last == i));
      done = e_dv && h_dready;

      @(posedge clk);
      m_cnt = m_cnt + int'(acc) - int'(done);
      if (done && m_last == N) m_eb = 0;
      if (acc) begin
         m_last = tgt;
         if (tgt == N) begin
            m_eb = 1; m_esrc = a_src; m_esize = a_size; m_euser = a_user;
            m_eop = (a_op == 3'd4) ? 3'd1 : 3'd0;
         end
      end
      @(negedge clk);
   endtask

   task automatic req(input bit v, input int s, input logic [2:0] op, input logic [IW-1:0] src);
      a_valid = v; sel = SW'(s); a_op = op; a_src = src;
      a_size = SZ'(src[1:0]); a_user = UW'(src + 3);
      a_addr = AW'(16'h1000 + src); a_data = {src, ~src, 16'hA55A}; a_mask = BW'(src | 1);
   endtask

   task automatic rsp(input int p, input bit v, input logic [2:0] op, input logic [IW-1:0] src);
      dv_dval[p] = v; r_op[p] = op; r_src[p] = src; r_size[p] = SZ'(p);
      r_data[p] = {8'hC0 + 8'(p), src, 16'h1234}; r_user[p] = UW'(p + 1); dv_derr[p] = 1'b0;
   endtask

   task automatic quiet();
      req(0, 0, 3'd0, 8'h00);
      for (int p = 0; p < N; p++) rsp(p, 0, 3'd0, 8'h00);
   endtask

   initial begin
      rst_n = 1'b0; h_dready = 1'b1; dv_ardy = '1; dv_derr = '0; dv_dval = '0;
      quiet();
      // R10: spurious device responses during reset are not forwarded
      for (int p = 0; p < N; p++) rsp(p, 1, 3'd1, 8'h77);
      repeat (3) @(negedge clk);
      chk("R10", "host_d_valid in reset", 128'(d_valid), 128'(0));
      chk("R10", "dev_d_ready in reset", 128'(dv_dready), 128'(0));
      rst_n = 1'b1;
      quiet();
      @(negedge clk);
      // R10: first request after reset may go anywhere
      req(1, 3, 3'd0, 8'h31);
      chk("R10", "first request ready", 128'(a_ready), 128'(1));
      cycle();
      req(0, 0, 3'd0, 8'h00); rsp(3, 1, 3'd0, 8'h31); cycle();
      rsp(3, 0, 3'd0, 8'h00); cycle();

      // R1 R5: write to port 1, ack; read to port 2
      req(1, 1, 3'd0, 8'h11); cycle();
      req(0, 0, 3'd0, 8'h00); rsp(1, 1, 3'd0, 8'h11); cycle();
      rsp(1, 0, 3'd0, 8'h00);
      req(1, 2, 3'd4, 8'h21); cycle();
      req(1, 2, 3'd4, 8'h22); cycle();
      // R3: port 0 blocked while port 2 outstanding
      req(1, 0, 3'd1, 8'h05); cycle(); cycle();
      rsp(2, 1, 3'd1, 8'h21); cycle();
      rsp(2, 1, 3'd1, 8'h22); cycle();
      rsp(2, 0, 3'd0, 8'h00); cycle();   // now drained, port 0 goes
      req(0, 0, 3'd0, 8'h00); rsp(0, 1, 3'd0, 8'h05); h_dready = 0; cycle();
      h_dready = 1; cycle();
      rsp(0, 0, 3'd0, 8'h00); cycle();

      // R2: device not ready
      dv_ardy[1] = 1'b0; req(1, 1, 3'd0, 8'h40); cycle(); cycle();
      dv_ardy[1] = 1'b1; cycle();
      req(0, 0, 3'd0, 8'h00); rsp(1, 1, 3'd0, 8'h40); cycle();
      rsp(1, 0, 3'd0, 8'h00); cycle();

      // R4: saturate port 3
      for (int k = 0; k < MO + 2; k++) begin
         req(1, 3, 3'd4, 8'(8'h50 + k)); cycle();
      end
      req(0, 0, 3'd0, 8'h00);
      for (int k = 0; k < MO; k++) begin
         rsp(3, 1, 3'd1, 8'(8'h50 + k)); cycle();
      end
      rsp(3, 0, 3'd0, 8'h00); cycle();

      // R6 R7 R8: error responder
      req(1, N, 3'd4, 8'h61); cycle();
      req(1, 7, 3'd0, 8'h62); h_dready = 0; cycle(); cycle();
      h_dready = 1; cycle();
      req(1, 5, 3'd1, 8'h63); cycle();
      req(1, 6, 3'd2, 8'h64); cycle();
      req(0, 0, 3'd0, 8'h00); cycle(); cycle();

      // R9: spurious response with nothing outstanding
      rsp(0, 1, 3'd1, 8'h99); rsp(2, 1, 3'd1, 8'h98); cycle(); cycle();
      quiet(); cycle();

      // Mixed random traffic
      for (int k = 0; k < 600; k++) begin
         req(($urandom % 3) != 0, int'($urandom % 8),
             ($urandom % 2) ? 3'd4 : 3'(($urandom % 2)), 8'($urandom));
         for (int p = 0; p < N; p++) begin
            rsp(p, ($urandom % 2) == 1, 3'($urandom % 2), 8'($urandom));
            dv_derr[p] = ($urandom % 5) == 0;
         end
         dv_ardy = N'($urandom);
         h_dready = ($urandom % 4) != 0;
         cycle();
      end

      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule